// File: doc/BRIEF.md
# Two-Master Memory Arbiter with Double-Pumped RAM

This block lets a host CPU and an interrupt coprocessor share one RAM and two flash banks. Everything runs on a single fast clock at twice the bus rate. A bus cycle is two fast cycles long. A slot sequencer alternates between two named states. `SLOT_CPU` is the first fast cycle of every bus cycle, and in it the RAM port serves the CPU. `SLOT_COP` is the second, and in it the RAM port serves the coprocessor. The transitions are `cpu_to_cop` and `cop_to_cpu`, and the sequencer takes one of them every fast clock. Both masters therefore get one RAM access in every bus cycle, and RAM traffic never causes a stall.

Flash is read-only and split into two banks. Bank A holds the coprocessor program; bank B is all other flash. The two masters may use different banks in the same bus cycle. The coprocessor stalls only when a CPU read targets the same flash bank in that bus cycle; the CPU always has priority. A small coprocessor state machine records stalls. In `COP_IDLE`, a conflict takes `stall_enter` to `COP_STALL`. In `COP_STALL`, a continuing conflict takes `stall_hold` and stays there. The first bus cycle without a conflict takes `stall_release` back to `COP_IDLE`, and the request is granted in that bus cycle.

Masters drive their inputs at the start of a bus cycle, when `slot_phase` is 0, and hold them for both fast cycles. Results appear one bus cycle later and stay constant for that whole bus cycle.

Top module: `dual_master_arb`

## Requirements
- R1: While `rst_n` is low, `slot_phase`, both ready outputs and both read-data outputs are 0.
- R2: `slot_phase` alternates between 0 and 1 on every fast clock. The value 0 marks the CPU RAM slot, which is the first half of a bus cycle, and 1 marks the coprocessor slot.
- R3: The CPU is never stalled. A CPU request in bus cycle n raises `cpu_ready` in bus cycle n+1. For a read, `cpu_rdata` in bus cycle n+1 holds the addressed word.
- R4: A coprocessor RAM access completes in every bus cycle, even while the CPU accesses RAM in every bus cycle.
- R5: When both masters access the same RAM word in one bus cycle, the CPU slot comes first and both accesses complete. After a CPU write, the coprocessor reads the new data. After a coprocessor write, the CPU reads the old data.
- R6: Flash accesses that target different banks in one bus cycle are both granted in that bus cycle.
- R7: A coprocessor access that targets the same flash bank as a CPU read in the same bus cycle is not granted, and `cop_ready` stays 0 in the next bus cycle. The access is granted in the first bus cycle without that conflict, with ready and data one bus cycle later.
- R8: A CPU write to flash gets `cpu_ready`, leaves flash contents unchanged and never stalls the coprocessor.
- R9: Address decoding works on 23-bit word addresses. RAM is 0x0FC000 to 0x0FC0FF, indexed by bits [7:0]. Bank A is 0x780000 to 0x79FFFF and reads as addr[15:0] XOR 0xC0DE. Bank B is the rest of 0x400000 to 0x7FFFFF and reads as addr[15:0] XOR 0xF1A5. Any other address is granted, reads as 0 and ignores writes.
- R10: Ready and read data change only at the end of a bus cycle. They hold through both fast cycles of the next bus cycle, and ready returns to 0 if no access was granted. Read data is 0 for writes and when nothing was granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_phase | output | 1 | 0 = CPU RAM slot (bus cycle start), 1 = coprocessor slot |
| cpu_req | input | 1 | CPU access request, held for a bus cycle |
| cpu_addr | input | 23 | CPU word address |
| cpu_we | input | 1 | CPU write enable |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data, one bus cycle after the request |
| cpu_ready | output | 1 | CPU access completed |
| cop_req | input | 1 | Coprocessor access request, held while stalled |
| cop_addr | input | 23 | Coprocessor word address |
| cop_we | input | 1 | Coprocessor write enable |
| cop_wdata | input | 16 | Coprocessor write data |
| cop_rdata | output | 16 | Coprocessor read data |
| cop_ready | output | 1 | Coprocessor access completed |

## Verification
The bench first streams RAM writes and reads from both masters in every bus cycle. With no stall expected, any missed `cop_ready` would point to slot contention rather than arbitration. Same-word RAM pairs are run in both directions, so that CPU-first ordering can be told apart from a race or from coprocessor-first ordering. Flash pairs cover different banks, the same bank with a CPU read (in both banks, released by CPU idle and by CPU moving to RAM) and the same bank with a CPU write. Together they separate a correct bank-conflict rule from one that stalls too often or too rarely. Window edges, an unmapped write just above RAM, and ready and data sampled in both halves of a bus cycle check decoding and output timing.

// File: rtl/arb_pkg.sv
package arb_pkg;

    parameter int unsigned DATA_W = 16;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_RAM,
        TGT_FLA,
        TGT_FLB
    } tgt_e;

    typedef enum logic {
        SLOT_CPU,
        SLOT_COP
    } slot_e;

    typedef enum logic {
        COP_IDLE,
        COP_STALL
    } cop_st_e;

    function automatic logic [DATA_W-1:0] flash_word(input logic [15:0] lo, input tgt_e t);
        logic [15:0] key;
        key = (t == TGT_FLA) ? 16'hC0DE : 16'hF1A5;
        return DATA_W'(lo ^ key);
    endfunction

    function automatic logic is_flash(input tgt_e t);
        return (t == TGT_FLA) || (t == TGT_FLB);
    endfunction

endpackage

// File: rtl/addr_decode.sv
module addr_decode
    import arb_pkg::*;
#(
    parameter int AW = 23,
    parameter int RAM_AW = 8,
    parameter logic [AW-1:0] RAM_LO = 23'h0F_C000,
    parameter logic [AW-1:0] FA_LO = 23'h78_0000,
    parameter logic [AW-1:0] FA_HI = 23'h79_FFFF,
    parameter logic [AW-1:0] FB_LO = 23'h40_0000,
    parameter logic [AW-1:0] FB_HI = 23'h7F_FFFF
) (
    input  logic [AW-1:0] addr,
    output tgt_e          tgt
);
    localparam logic [AW-1:0] RAM_HI = RAM_LO + AW'((1 << RAM_AW) - 1);

    always_comb begin
        if (addr >= RAM_LO && addr <= RAM_HI) begin
            tgt = TGT_RAM;
        end else if (addr >= FA_LO && addr <= FA_HI) begin
            tgt = TGT_FLA;
        end else if (addr >= FB_LO && addr <= FB_HI) begin
            tgt = TGT_FLB;
        end else begin
            tgt = TGT_NONE;
        end
    end
endmodule

// File: rtl/slot_seq.sv
module slot_seq
    import arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);
    slot_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_CPU;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SLOT_CPU: state_d = SLOT_COP;   // cpu_to_cop
            SLOT_COP: state_d = SLOT_CPU;   // cop_to_cpu
            default:  state_d = SLOT_CPU;
        endcase
    end

    assign slot = state_q;

    // R2
    slot_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_CPU) |=> (slot == SLOT_COP));
endmodule

// File: rtl/ram_pump.sv
module ram_pump
    import arb_pkg::*;
#(
    parameter int DW = 16,
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             slot,
    input  logic              cpu_en,
    input  logic              cpu_we,
    input  logic [RAM_AW-1:0] cpu_idx,
    input  logic [DW-1:0]     cpu_wd,
    input  logic              cop_en,
    input  logic              cop_we,
    input  logic [RAM_AW-1:0] cop_idx,
    input  logic [DW-1:0]     cop_wd,
    output logic [DW-1:0]     cpu_rd,
    output logic [DW-1:0]     cop_rd
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (slot == SLOT_CPU && cpu_en && cpu_we) begin
            mem[cpu_idx] <= cpu_wd;
        end else if (slot == SLOT_COP && cop_en && cop_we) begin
            mem[cop_idx] <= cop_wd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rd <= '0;
        end else if (slot == SLOT_CPU && cpu_en && !cpu_we) begin
            cpu_rd <= mem[cpu_idx];
        end
    end

    // The coprocessor slot follows the CPU slot, so this read sees a same-cycle CPU write.
    assign cop_rd = mem[cop_idx];

    // R5
    cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_COP) |=> $stable(cpu_rd));
endmodule

// File: rtl/flash_arb.sv
module flash_arb
    import arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_e slot,
    input  logic  cpu_req,
    input  logic  cpu_we,
    input  tgt_e  cpu_tgt,
    input  logic  cop_req,
    input  tgt_e  cop_tgt,
    output logic  stall,
    output cop_st_e cop_state
);
    cop_st_e state_d;

    assign stall = cop_req && cpu_req && !cpu_we && is_flash(cop_tgt) && (cop_tgt == cpu_tgt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cop_state <= COP_IDLE;
        end else if (slot == SLOT_COP) begin
            cop_state <= state_d;
        end
    end

    always_comb begin
        unique case (cop_state)
            COP_IDLE:  state_d = stall ? COP_STALL : COP_IDLE;   // stall_enter
            COP_STALL: state_d = stall ? COP_STALL : COP_IDLE;   // stall_hold / stall_release
            default:   state_d = COP_IDLE;
        endcase
    end

    // R6
    bank_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cop_req && cpu_tgt != cop_tgt) |-> !stall);
endmodule

// File: rtl/dual_master_arb.sv
module dual_master_arb
    import arb_pkg::*;
#(
    parameter int AW = 23,
    parameter int DW = arb_pkg::DATA_W,
    parameter int RAM_AW = 8,
    parameter logic [AW-1:0] RAM_LO = 23'h0F_C000,
    parameter logic [AW-1:0] FA_LO = 23'h78_0000,
    parameter logic [AW-1:0] FA_HI = 23'h79_FFFF,
    parameter logic [AW-1:0] FB_LO = 23'h40_0000,
    parameter logic [AW-1:0] FB_HI = 23'h7F_FFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          slot_phase,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_we,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ready,
    input  logic          cop_req,
    input  logic [AW-1:0] cop_addr,
    input  logic          cop_we,
    input  logic [DW-1:0] cop_wdata,
    output logic [DW-1:0] cop_rdata,
    output logic          cop_ready
);
    slot_e   slot;
    tgt_e    cpu_tgt, cop_tgt;
    logic    stall;
    cop_st_e cop_state;
    logic [DW-1:0] cpu_ram_rd, cop_ram_rd;
    logic [DW-1:0] cpu_rd_d, cop_rd_d;
    logic    cop_grant;

    slot_seq u_seq (.clk(clk), .rst_n(rst_n), .slot(slot));

    addr_decode #(.AW(AW), .RAM_AW(RAM_AW), .RAM_LO(RAM_LO), .FA_LO(FA_LO),
                  .FA_HI(FA_HI), .FB_LO(FB_LO), .FB_HI(FB_HI))
        u_dec_cpu (.addr(cpu_addr), .tgt(cpu_tgt));

    addr_decode #(.AW(AW), .RAM_AW(RAM_AW), .RAM_LO(RAM_LO), .FA_LO(FA_LO),
                  .FA_HI(FA_HI), .FB_LO(FB_LO), .FB_HI(FB_HI))
        u_dec_cop (.addr(cop_addr), .tgt(cop_tgt));

    ram_pump #(.DW(DW), .RAM_AW(RAM_AW)) u_ram (
        .clk(clk), .rst_n(rst_n), .slot(slot),
        .cpu_en(cpu_req && cpu_tgt == TGT_RAM), .cpu_we(cpu_we),
        .cpu_idx(cpu_addr[RAM_AW-1:0]), .cpu_wd(cpu_wdata),
        .cop_en(cop_req && cop_tgt == TGT_RAM), .cop_we(cop_we),
        .cop_idx(cop_addr[RAM_AW-1:0]), .cop_wd(cop_wdata),
        .cpu_rd(cpu_ram_rd), .cop_rd(cop_ram_rd));

    flash_arb u_flash (
        .clk(clk), .rst_n(rst_n), .slot(slot),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tgt(cpu_tgt),
        .cop_req(cop_req), .cop_tgt(cop_tgt),
        .stall(stall), .cop_state(cop_state));

    assign cop_grant = cop_req && !stall;

    always_comb begin
        unique case (cpu_tgt)
            TGT_RAM:          cpu_rd_d = cpu_ram_rd;
            TGT_FLA, TGT_FLB: cpu_rd_d = flash_word(cpu_addr[15:0], cpu_tgt);
            default:          cpu_rd_d = '0;
        endcase
        unique case (cop_tgt)
            TGT_RAM:          cop_rd_d = cop_ram_rd;
            TGT_FLA, TGT_FLB: cop_rd_d = flash_word(cop_addr[15:0], cop_tgt);
            default:          cop_rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_ready <= 1'b0;
            cpu_rdata <= '0;
            cop_ready <= 1'b0;
            cop_rdata <= '0;
        end else if (slot == SLOT_COP) begin
            cpu_ready <= cpu_req;
            cpu_rdata <= (cpu_req && !cpu_we) ? cpu_rd_d : '0;
            cop_ready <= cop_grant;
            cop_rdata <= (cop_grant && !cop_we) ? cop_rd_d : '0;
        end
    end

    assign slot_phase = (slot == SLOT_COP);

    // R3
    cpu_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_COP && cpu_req) |=> cpu_ready);

    // R4
    cop_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_COP && cop_req && cop_tgt == TGT_RAM) |=> cop_ready);

    // R7
    cop_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_COP && stall) |=> !cop_ready);

    // R7
    cop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_COP && cop_state == COP_STALL && cop_req && !stall) |=> cop_ready);

    // R10
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_CPU) |=> ($stable(cpu_ready) && $stable(cop_ready)
                                && $stable(cpu_rdata) && $stable(cop_rdata)));
endmodule

// File: tb/tb_dual_master_arb.sv
module tb_dual_master_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_phase;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cop_req = 1'b0, cop_we = 1'b0;
    logic [22:0] cpu_addr = '0, cop_addr = '0;
    logic [15:0] cpu_wdata = '0, cop_wdata = '0;
    logic [15:0] cpu_rdata, cop_rdata;
    logic        cpu_ready, cop_ready;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dual_master_arb dut (
        .clk(clk), .rst_n(rst_n), .slot_phase(slot_phase),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .cop_req(cop_req), .cop_addr(cop_addr), .cop_we(cop_we), .cop_wdata(cop_wdata),
        .cop_rdata(cop_rdata), .cop_ready(cop_ready));

    function automatic logic [15:0] exp_flash(input logic [22:0] a);
        if (a >= 23'h78_0000 && a <= 23'h79_FFFF) return a[15:0] ^ 16'hC0DE;
        if (a >= 23'h40_0000 && a <= 23'h7F_FFFF) return a[15:0] ^ 16'hF1A5;
        return 16'h0000;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_drv(input logic r, input logic [22:0] a, input logic w, input logic [15:0] d);
        cpu_req = r; cpu_addr = a; cpu_we = w; cpu_wdata = d;
    endtask

    task automatic cop_drv(input logic r, input logic [22:0] a, input logic w, input logic [15:0] d);
        cop_req = r; cop_addr = a; cop_we = w; cop_wdata = d;
    endtask

    task automatic idle();
        cpu_drv(0, '0, 0, '0);
        cop_drv(0, '0, 0, '0);
    endtask

    // One bus cycle: inputs are driven at a phase-0 negedge, results are read two negedges later.
    task automatic step();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 slot_phase", {15'd0, slot_phase}, 16'h0);
        chk("R1 cpu_ready", {15'd0, cpu_ready}, 16'h0);
        chk("R1 cop_ready", {15'd0, cop_ready}, 16'h0);
        chk("R1 cpu_rdata", cpu_rdata, 16'h0);
        chk("R1 cop_rdata", cop_rdata, 16'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_phase();
        chk("R2 phase first half", {15'd0, slot_phase}, 16'h0);
        @(negedge clk);
        chk("R2 phase second half", {15'd0, slot_phase}, 16'h1);
        @(negedge clk);
        chk("R2 phase next cycle", {15'd0, slot_phase}, 16'h0);
    endtask

    task automatic t_ram_cpu();
        cpu_drv(1, 23'h0F_C010, 1, 16'h1234); step();
        chk("R3 write ready", {15'd0, cpu_ready}, 16'h1);
        cpu_drv(1, 23'h0F_C010, 0, 16'h0); step();
        chk("R3 read ready", {15'd0, cpu_ready}, 16'h1);
        chk("R3 read data", cpu_rdata, 16'h1234);
        idle(); step();
        chk("R10 ready drops", {15'd0, cpu_ready}, 16'h0);
    endtask

    task automatic t_ram_stream();
        for (int i = 0; i < 6; i++) begin
            cpu_drv(1, 23'h0F_C020 + 23'(i), 1, 16'h1000 + 16'(i));
            cop_drv(1, 23'h0F_C040 + 23'(i), 1, 16'h2000 + 16'(i));
            step();
            chk("R4 cop write ready", {15'd0, cop_ready}, 16'h1);
        end
        for (int i = 0; i < 6; i++) begin
            cpu_drv(1, 23'h0F_C040 + 23'(i), 0, 16'h0);
            cop_drv(1, 23'h0F_C020 + 23'(i), 0, 16'h0);
            step();
            chk("R4 cop read ready", {15'd0, cop_ready}, 16'h1);
            chk("R4 cop read data", cop_rdata, 16'h1000 + 16'(i));
            chk("R4 cpu read data", cpu_rdata, 16'h2000 + 16'(i));
        end
        idle();
    endtask

    task automatic t_same_addr();
        cpu_drv(1, 23'h0F_C080, 1, 16'hBEEF);
        cop_drv(1, 23'h0F_C080, 0, 16'h0); step();
        chk("R5 cop sees cpu write", cop_rdata, 16'hBEEF);
        chk("R5 cop ready", {15'd0, cop_ready}, 16'h1);
        cpu_drv(1, 23'h0F_C080, 0, 16'h0);
        cop_drv(1, 23'h0F_C080, 1, 16'hCAFE); step();
        chk("R5 cpu reads old", cpu_rdata, 16'hBEEF);
        chk("R5 both ready", {14'd0, cpu_ready, cop_ready}, 16'h3);
        cop_drv(0, '0, 0, '0); step();
        chk("R5 cop write landed", cpu_rdata, 16'hCAFE);
        idle();
    endtask

    task automatic t_flash_par();
        cpu_drv(1, 23'h41_2345, 0, 16'h0);
        cop_drv(1, 23'h78_1234, 0, 16'h0); step();
        chk("R6 both ready B/A", {14'd0, cpu_ready, cop_ready}, 16'h3);
        chk("R6 cpu bank B data", cpu_rdata, exp_flash(23'h41_2345));
        chk("R6 cop bank A data", cop_rdata, exp_flash(23'h78_1234));
        cpu_drv(1, 23'h79_FFFF, 0, 16'h0);
        cop_drv(1, 23'h7F_0000, 0, 16'h0); step();
        chk("R6 both ready A/B", {14'd0, cpu_ready, cop_ready}, 16'h3);
        chk("R9 bank A top", cpu_rdata, exp_flash(23'h79_FFFF));
        chk("R9 bank B data", cop_rdata, exp_flash(23'h7F_0000));
        idle();
    endtask

    task automatic t_conflict();
        cpu_drv(1, 23'h78_0010, 0, 16'h0);
        cop_drv(1, 23'h78_0020, 0, 16'h0); step();
        chk("R7 cpu wins", cpu_rdata, exp_flash(23'h78_0010));
        chk("R7 cop stalled 1", {15'd0, cop_ready}, 16'h0);
        step();
        chk("R7 cop stalled 2", {15'd0, cop_ready}, 16'h0);
        cpu_drv(0, '0, 0, '0); step();
        chk("R7 release ready", {15'd0, cop_ready}, 16'h1);
        chk("R7 release data", cop_rdata, exp_flash(23'h78_0020));
        cpu_drv(1, 23'h50_0000, 0, 16'h0);
        cop_drv(1, 23'h50_0004, 0, 16'h0); step();
        chk("R7 bank B stall", {15'd0, cop_ready}, 16'h0);
        cpu_drv(1, 23'h0F_C010, 0, 16'h0); step();
        chk("R7 release on cpu move", {15'd0, cop_ready}, 16'h1);
        chk("R7 bank B data", cop_rdata, exp_flash(23'h50_0004));
        idle();
    endtask

    task automatic t_flash_write();
        cpu_drv(1, 23'h78_0030, 1, 16'hFFFF);
        cop_drv(1, 23'h78_0030, 0, 16'h0); step();
        chk("R8 cpu write ready", {15'd0, cpu_ready}, 16'h1);
        chk("R8 cop not stalled", {15'd0, cop_ready}, 16'h1);
        chk("R8 cop data", cop_rdata, exp_flash(23'h78_0030));
        cpu_drv(1, 23'h78_0030, 0, 16'h0);
        cop_drv(0, '0, 0, '0); step();
        chk("R8 flash unchanged", cpu_rdata, exp_flash(23'h78_0030));
        idle();
    endtask

    task automatic t_decode();
        cpu_drv(1, 23'h00_1000, 0, 16'h0);
        cop_drv(1, 23'h77_FFFF, 0, 16'h0); step();
        chk("R9 unmapped ready", {15'd0, cpu_ready}, 16'h1);
        chk("R9 unmapped data", cpu_rdata, 16'h0);
        chk("R9 below bank A is B", cop_rdata, 16'hFFFF ^ 16'hF1A5);
        cop_drv(0, '0, 0, '0);
        cpu_drv(1, 23'h0F_C000, 1, 16'h7777); step();
        cpu_drv(1, 23'h0F_C100, 1, 16'h1111); step();
        cpu_drv(1, 23'h0F_C100, 0, 16'h0); step();
        chk("R9 above RAM reads 0", cpu_rdata, 16'h0);
        cpu_drv(1, 23'h0F_C000, 0, 16'h0); step();
        chk("R9 no RAM alias", cpu_rdata, 16'h7777);
        cpu_drv(1, 23'h0F_C0FF, 1, 16'h5A5A); step();
        cpu_drv(1, 23'h0F_C0FF, 0, 16'h0); step();
        chk("R9 RAM top word", cpu_rdata, 16'h5A5A);
        idle();
    endtask

    task automatic t_hold();
        cpu_drv(1, 23'h45_6789, 0, 16'h0); step();
        chk("R10 ready phase0", {15'd0, cpu_ready}, 16'h1);
        idle();
        @(negedge clk);
        chk("R10 ready phase1", {15'd0, cpu_ready}, 16'h1);
        chk("R10 data phase1", cpu_rdata, exp_flash(23'h45_6789));
        @(negedge clk);
        chk("R10 ready cleared", {15'd0, cpu_ready}, 16'h0);
        chk("R10 data cleared", cpu_rdata, 16'h0);
    endtask

    initial begin
        t_reset();
        t_phase();
        t_ram_cpu();
        t_ram_stream();
        t_same_addr();
        t_flash_par();
        t_conflict();
        t_flash_write();
        t_decode();
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule